// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software run one clause-22 management transaction on an MDIO bus at a time. Software sees three words on a small 32-bit register port: a command word, a data word and a read-status word. A valid command sets a busy flag. The controller then sends a complete management frame toward the PHY, clocking it on MDC, and clears busy by itself when the frame ends.

For a write, software first places the 16-bit value in the low half of the data word and then issues the command. For a read, the controller releases the data line from the turnaround onward and samples the PHY's bits. When the frame ends it places the captured value in the upper half of the data word and records in the status word whether the PHY actually answered. Software polls busy before it issues a command and again before it collects read results.

MDC is produced from the system clock by a parameterised divider, `CLK_DIV` system clocks per MDC half-period. The outgoing bit changes on the MDC falling edge and the incoming bit is sampled on the rising edge.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, all three register words read as zero, MDC is low and the data-line output enable is low.
- R2: A write to word 0 (`reg_addr` 0) is accepted only while idle, only with bit 20 set and only with exactly one of bit 17 (read) and bit 16 (write) set. Acceptance sets busy in the next cycle. Word 0 reads back busy at bit 20, the read/write opcode bits at 17/16, the PHY address at bits 12:8 and the register number at bits 4:0. The command fields persist after completion.
- R3: Busy stays set for exactly 128*CLK_DIV clock cycles, which is 64 MDC periods, and then clears on its own.
- R4: While busy, MDC has a period of 2*CLK_DIV clocks, starting low for CLK_DIV clocks after acceptance. While idle, MDC and the output enable are low.
- R5: The bits driven are, in order:
  - 32 ones;
  - the start pattern 0,1;
  - the opcode, which is 1,0 for a read and 0,1 for a write;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register number, MSB first.
  
  A write frame then continues with the turnaround 1,0 and the 16 bits of data-word bits 15:0, MSB first.
- R6: On a read, the output enable drops from the first turnaround bit (bit 46 of the frame) to the end of the frame. The last 16 bits are sampled from `mdio_in` on MDC rising edges, MSB first. They appear in data-word bits 31:16 when busy clears.
- R7: Word 2 bit 0 is the invalid flag. It is set when a read ends if the second turnaround bit was sampled high, and cleared when a read ends with that bit low. Write frames leave it unchanged.
- R8: While busy, writes to the command word and to the data word are ignored. The frame in flight and the data word are unaffected.
- R9: A command write with bit 20 clear, or with both or neither opcode bits set, is ignored. Busy stays clear and MDC stays low.
- R10: The output and output enable change only when MDC falls. They hold steady for the whole high phase of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 command, 1 data, 2 read status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word (combinational) |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line as seen at the pin |

## Verification
A behavioural reference predicts MDC, the driven bit, the output enable and the selected register word on every clock. A bus-level PHY model captures each frame and answers reads only at one address.

Write frames carrying an asymmetric data pattern separate opcode, address and data bit orders. Reads from the answering address, with the patterns 0x8E71 and 0x0001, separate MSB-first capture from an off-by-one sample point. A read from a silent address tells a released bus apart from an answered one through the invalid flag, and a write that follows it shows that writes leave the flag alone. Malformed commands, and commands or data written mid-frame, show that only well-formed idle commands reach the bus.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT = 46;

  logic          busy, op_rd, op_wr, ta_bad, invalid;
  logic [4:0]    phy, regn;
  logic [15:0]   data_lo, data_hi, shreg;
  logic [CW-1:0] cnt;
  logic [5:0]    bit_idx;
  logic [FRAME_BITS-1:0] frame;

  wire cmd_ok  = reg_wdata[20] && (reg_wdata[17] ^ reg_wdata[16]);
  wire accept  = reg_we && reg_addr == 2'd0 && !busy && cmd_ok;
  wire half_end = cnt == CW'(CLK_DIV - 1);
  wire rise    = busy && half_end && !mdc;
  wire fall    = busy && half_end && mdc;
  wire last    = fall && bit_idx == 6'(FRAME_BITS - 1);

  assign mdio_out = frame[FRAME_BITS-1] & mdio_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; op_rd <= 1'b0; op_wr <= 1'b0; phy <= '0; regn <= '0;
      data_lo <= '0; data_hi <= '0; shreg <= '0; invalid <= 1'b0; ta_bad <= 1'b0;
      cnt <= '0; mdc <= 1'b0; mdio_oe <= 1'b0; bit_idx <= '0; frame <= '0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        op_rd   <= reg_wdata[17];
        op_wr   <= reg_wdata[16];
        phy     <= reg_wdata[12:8];
        regn    <= reg_wdata[4:0];
        cnt     <= '0;
        mdc     <= 1'b0;
        bit_idx <= '0;
        ta_bad  <= 1'b0;
        mdio_oe <= 1'b1;
        frame   <= {32'hFFFF_FFFF, 2'b01, reg_wdata[17] ? 2'b10 : 2'b01,
                    reg_wdata[12:8], reg_wdata[4:0],
                    reg_wdata[17] ? 18'h0 : {2'b10, data_lo}};
      end else if (busy) begin
        cnt <= half_end ? '0 : cnt + 1'b1;
        if (half_end) mdc <= ~mdc;
        if (rise && op_rd) begin
          if (bit_idx == 6'(TA_BIT + 1)) ta_bad <= mdio_in;
          if (bit_idx >= 6'(TA_BIT + 2)) shreg <= {shreg[14:0], mdio_in};
        end
        if (last) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (op_rd) begin
            data_hi <= shreg;
            invalid <= ta_bad;
          end
        end else if (fall) begin
          bit_idx <= bit_idx + 1'b1;
          frame   <= frame << 1;
          mdio_oe <= op_wr || bit_idx < 6'(TA_BIT - 1);
        end
      end
      if (reg_we && reg_addr == 2'd1 && !busy) data_lo <= reg_wdata[15:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {11'b0, busy, 2'b0, op_rd, op_wr, 3'b0, phy, 3'b0, regn};
      2'd1:    reg_rdata = {data_hi, data_lo};
      2'd2:    reg_rdata = {31'b0, invalid};
      default: reg_rdata = '0;
    endcase
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mdio_oe && mdio_out && !mdc));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
  assert_read_released_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && op_rd && bit_idx >= 6'(TA_BIT)) |-> !mdio_oe);
  assert_result_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> ($stable(invalid) && $stable(data_hi)));
  assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_addr == 2'd0) |=> ($stable(phy) && $stable(regn) && $stable(op_rd)));
  assert_hold_high_R10: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_cmd_ctrl_test.sv
module mdio_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int FRAME_CLKS = 128 * DIV;
  localparam logic [4:0] PHY_ADDR = 5'h01;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, mdio_in = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_out, mdio_oe;

  mdio_cmd_ctrl #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  integer checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference model
  bit mbusy = 0, mrd = 0, mwr = 0, minv = 0;
  logic [4:0] mphy = '0, mreg = '0;
  logic [15:0] mlo = '0, mhi = '0;
  logic [63:0] mframe = '0;
  integer j = 0;
  logic [15:0] phy_val = '0;

  always @(posedge clk) begin
    bit was_busy;
    was_busy = mbusy;
    if (rst) begin
      mbusy = 0; mrd = 0; mwr = 0; minv = 0; mphy = '0; mreg = '0; mlo = '0; mhi = '0;
    end else begin
      if (mbusy) begin
        j++;
        if (j == FRAME_CLKS) begin
          mbusy = 0;
          if (mrd) begin
            if (mphy == PHY_ADDR) begin mhi = phy_val; minv = 0; end
            else begin mhi = 16'hFFFF; minv = 1; end
          end
        end
      end else if (reg_we && reg_addr == 2'd0 && reg_wdata[20] && (reg_wdata[17] != reg_wdata[16])) begin
        mbusy = 1; j = 0; mrd = reg_wdata[17]; mwr = reg_wdata[16];
        mphy = reg_wdata[12:8]; mreg = reg_wdata[4:0];
        mframe = {32'hFFFF_FFFF, 2'b01, mrd ? 2'b10 : 2'b01, mphy, mreg, mrd ? 18'h0 : {2'b10, mlo}};
      end
      if (reg_we && reg_addr == 2'd1 && !was_busy) mlo = reg_wdata[15:0];
    end
  end

  logic prev_mdc = 0, prev_out = 0, prev_oe = 0;
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst) begin
      integer k;
      logic emdc, eoe, eout;
      logic [31:0] erd;
      k = j / (2 * DIV);
      emdc = mbusy && ((j / DIV) % 2 == 1);
      eoe = mbusy && (mwr || k < 46);
      eout = eoe && mframe[63 - k];
      chk(mdc === emdc, "R4 mdc", {31'b0, mdc}, {31'b0, emdc});
      chk(mdio_oe === eoe, "R6 output enable", {31'b0, mdio_oe}, {31'b0, eoe});
      chk(mdio_out === eout, "R5 frame bit", {31'b0, mdio_out}, {31'b0, eout});
      case (reg_addr)
        2'd0: erd = {11'b0, mbusy, 2'b0, mrd, mwr, 3'b0, mphy, 3'b0, mreg};
        2'd1: erd = {mhi, mlo};
        2'd2: erd = {31'b0, minv};
        default: erd = '0;
      endcase
      chk(reg_rdata === erd, "R2 register word", reg_rdata, erd);
      if (prev_mdc && mdc)
        chk(mdio_out === prev_out && mdio_oe === prev_oe, "R10 hold while high",
            {30'b0, mdio_oe, mdio_out}, {30'b0, prev_oe, prev_out});
      prev_mdc = mdc; prev_out = mdio_out; prev_oe = mdio_oe;
    end
  end

  // PHY model
  integer rises = 0;
  logic [63:0] rx = '0;
  always @(posedge mdc) begin
    if (rises < 64) rx[63 - rises] = mdio_oe ? mdio_out : 1'b1;
    rises++;
  end
  always @(negedge mdc) begin
    if (rx[29:28] == 2'b10 && rx[27:23] == PHY_ADDR && rises == 47) mdio_in = 1'b0;
    else if (rx[29:28] == 2'b10 && rx[27:23] == PHY_ADDR && rises >= 48 && rises <= 63)
      mdio_in = phy_val[63 - rises];
    else mdio_in = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic issue(input logic [31:0] d);
    rises = 0; rx = '0; mdio_in = 1'b1;
    wr(2'd0, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_addr = 2'd0;
  endtask

  task automatic wait_idle();
    while (mbusy) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [31:0] CMD_RD = 32'h0012_0000;
  localparam logic [31:0] CMD_WR = 32'h0011_0000;

  initial begin
    logic [31:0] v;
    integer n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk(v == 0, "R1 command word", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 data word", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 status word", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins idle", {30'b0, mdc, mdio_oe}, 0);

    wr(2'd1, 32'h0000_A53C);
    issue(CMD_WR | (32'h13 << 8) | 32'h0A);
    n = 0;
    while (reg_rdata[20]) begin n++; @(negedge clk); end
    chk(n == FRAME_CLKS, "R3 busy length", n, FRAME_CLKS);
    wait_idle();
    chk(rx == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA53C},
        "R5 write frame at PHY", rx[31:0], {5'h13, 5'h0A, 2'b10, 16'hA53C} );

    phy_val = 16'h8E71;
    issue(CMD_RD | (32'(PHY_ADDR) << 8) | 32'h1F);
    wait_idle();
    rd(2'd1, v); chk(v == 32'h8E71_A53C, "R6 read data upper half", v, 32'h8E71_A53C);
    rd(2'd2, v); chk(v == 0, "R7 valid read", v, 0);

    issue(CMD_RD | (32'h07 << 8) | 32'h02);
    wait_idle();
    rd(2'd2, v); chk(v == 1, "R7 absent PHY invalid", v, 1);
    rd(2'd1, v); chk(v[31:16] == 16'hFFFF, "R6 released bus reads ones", v, 32'hFFFF_A53C);

    issue(CMD_WR | (32'h02 << 8) | 32'h03);
    wait_idle();
    rd(2'd2, v); chk(v == 1, "R7 write leaves flag", v, 1);

    phy_val = 16'h0001;
    issue(CMD_RD | (32'(PHY_ADDR) << 8) | 32'h04);
    wait_idle();
    rd(2'd2, v); chk(v == 0, "R7 flag cleared", v, 0);
    rd(2'd1, v); chk(v == 32'h0001_A53C, "R6 lsb capture", v, 32'h0001_A53C);

    wr(2'd0, 32'h0002_0105);
    repeat (10) @(negedge clk);
    chk(!reg_rdata[20] && !mdc, "R9 no busy bit", reg_rdata, 0);
    wr(2'd0, 32'h0013_0105);
    repeat (10) @(negedge clk);
    chk(!reg_rdata[20] && !mdc, "R9 both opcodes", reg_rdata, 0);
    wr(2'd0, 32'h0010_0105);
    repeat (10) @(negedge clk);
    chk(!reg_rdata[20] && !mdc, "R9 no opcode", reg_rdata, 0);

    phy_val = 16'h3C5A;
    issue(CMD_RD | (32'(PHY_ADDR) << 8) | 32'h11);
    repeat (40) @(negedge clk);
    wr(2'd0, CMD_WR | (32'h05 << 8) | 32'h06);
    wr(2'd1, 32'h0000_7777);
    wait_idle();
    rd(2'd0, v);
    chk(v == ((CMD_RD & ~32'h0010_0000) | (32'(PHY_ADDR) << 8) | 32'h11), "R8 command kept", v,
        (CMD_RD & ~32'h0010_0000) | (32'(PHY_ADDR) << 8) | 32'h11);
    rd(2'd1, v); chk(v == 32'h3C5A_A53C, "R8 data kept", v, 32'h3C5A_A53C);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule